// File: doc/BRIEF.md
# Unified Data Memory with Frame Buffer and Keyboard Word

This block presents one flat, word-addressed data space behind a single RAM-like port. The address space holds three kinds of storage: a bank of general data words, a bitmapped monochrome frame buffer, and a single word that mirrors the code of the key now held on an external keyboard. A processor drives an address, a write value and a load strobe, and sees the addressed word on a combinational read output. External display logic fetches frame-buffer words through a separate read-only port, independently of the processor port.

The map is fixed and derived from the address width `ADDR_W`. The lower half of the space is data RAM. The next quarter is the frame buffer. The first word of the top quarter is the keyboard word, and every address above it is unmapped. With `ADDR_W = 15` the regions are 0x0000–0x3FFF (16K data words), 0x4000–0x5FFF (8K frame-buffer words, 256 rows of 512 pixels) and 0x6000 (keyboard). The default build uses `ADDR_W = 11`: data at 0x000–0x3FF, frame buffer at 0x400–0x5FF (16 rows of 512 pixels) and keyboard at 0x600. The storage is not cleared by reset.

Top module: `mmio_datamem`

## Requirements
- R1: The top address bit selects data RAM when 0. The top two bits equal to binary 10 select the frame buffer. The word at 3·2^(ADDR_W-2) is the keyboard word. Within each store, the offset is the low address bits.
- R2: `rd_data` is a combinational read of the addressed word. A write with `load` high commits `wr_data` at the next rising clock edge, and it is visible on `rd_data` right after that edge.
- R3: Data RAM and the frame buffer are separate stores. A write to a word in one region leaves the word at the same offset in the other region unchanged.
- R4: A read of the keyboard address returns `kbd_code` as it is in that cycle. A value of 0 means no key is pressed.
- R5: Every address above the keyboard word reads as 0.
- R6: A write to the keyboard address or to any address above it changes no stored word.
- R7: `pix_data` returns frame-buffer word `pix_addr`, which is the same word the processor sees at frame-buffer base + `pix_addr`. Pixel (row r, column c) is bit c mod 16 of word 32·r + c/16, with bit 0 the leftmost pixel of the word. A bit value of 1 is black and 0 is white.
- R8: While `rst` is high, `load` is ignored and no stored word changes.
- R9: The processor port can both read and write frame-buffer words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| wr_data | input | DATA_W (16) | Value to write |
| addr | input | ADDR_W (11) | Word address on the processor port |
| load | input | 1 | Write strobe |
| kbd_code | input | DATA_W (16) | Code of the pressed key, 0 when none |
| rd_data | output | DATA_W (16) | Word read at `addr` |
| pix_addr | input | ADDR_W-2 (9) | Frame-buffer word index for the display port |
| pix_data | output | DATA_W (16) | Frame-buffer word at `pix_addr` |

## Verification
On every cycle the assertions check the following: a written word reads back the next cycle, the keyboard address mirrors the keyboard input, addresses above the keyboard read zero, and neither store receives a write strobe for unmapped addresses or during reset. The bench scenarios are needed for the rest: that data RAM and frame buffer do not alias at equal offsets, that a pixel at a given row and column lands at the expected word and bit of the display port, and that an ignored write leaves the earlier contents of both stores intact at region boundaries.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

    // Region selected by an address on the processor port
    typedef enum logic [1:0] {
        RGN_RAM  = 2'd0,
        RGN_FB   = 2'd1,
        RGN_KBD  = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    // Decoded view of one processor access
    typedef struct packed {
        region_e region;
        logic    ram_we;
        logic    fb_we;
    } access_t;

    // Write strobes for a region, given load and reset
    function automatic access_t make_access(region_e rgn, logic load, logic rst);
        access_t a;
        a.region = rgn;
        a.ram_we = load && !rst && (rgn == RGN_RAM);
        a.fb_we  = load && !rst && (rgn == RGN_FB);
        return a;
    endfunction

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    localparam int LOW_W = ADDR_W - 2;

    logic [1:0]       top_bits;
    logic [LOW_W-1:0] low_bits;

    assign top_bits = addr[ADDR_W-1 -: 2];
    assign low_bits = addr[LOW_W-1:0];

    // Upper bits pick a bank, as when larger memories are built from smaller ones
    always_comb begin
        unique case (top_bits)
            2'b00, 2'b01: region = RGN_RAM;
            2'b10:        region = RGN_FB;
            default:      region = (low_bits == '0) ? RGN_KBD : RGN_NONE;
        endcase
    end
endmodule

// File: rtl/mmio_bank.sv
module mmio_bank #(
    parameter int DATA_W = 16,
    parameter int AW     = 10,
    parameter int N_RD   = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [N_RD*AW-1:0]     rd_addr,
    output logic [N_RD*DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < N_RD; p++) begin : g_rd
        logic [AW-1:0] ra;
        assign ra = rd_addr[p*AW +: AW];
        assign rd_data[p*DATA_W +: DATA_W] = mem[ra];

        // R2: a committed write is seen on every read port one cycle later
        a_r2_write_commit: assert property (@(posedge clk) disable iff (rst)
            ($past(wr_en) && ra == $past(wr_addr))
                |-> rd_data[p*DATA_W +: DATA_W] == $past(wr_data))
            else $error("a_r2_write_commit port %0d", p);
    end
endmodule

// File: rtl/mmio_datamem.sv
module mmio_datamem
    import mmio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              load,
    input  logic [DATA_W-1:0] kbd_code,
    output logic [DATA_W-1:0] rd_data,
    input  logic [ADDR_W-3:0] pix_addr,
    output logic [DATA_W-1:0] pix_data
);
    localparam int RAM_AW = ADDR_W - 1;
    localparam int FB_AW  = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] KBD_ADDR = ADDR_W'(3) << FB_AW;

    region_e region;
    access_t acc;

    logic [DATA_W-1:0]   ram_word;
    logic [2*DATA_W-1:0] fb_words;

    mmio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (addr),
        .region (region)
    );

    assign acc = make_access(region, load, rst);

    mmio_bank #(.DATA_W(DATA_W), .AW(RAM_AW), .N_RD(1)) u_ram (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (acc.ram_we),
        .wr_addr (addr[RAM_AW-1:0]),
        .wr_data (wr_data),
        .rd_addr (addr[RAM_AW-1:0]),
        .rd_data (ram_word)
    );

    // Port 0 serves the processor, port 1 the display fetch
    mmio_bank #(.DATA_W(DATA_W), .AW(FB_AW), .N_RD(2)) u_fb (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (acc.fb_we),
        .wr_addr (addr[FB_AW-1:0]),
        .wr_data (wr_data),
        .rd_addr ({pix_addr, addr[FB_AW-1:0]}),
        .rd_data (fb_words)
    );

    assign pix_data = fb_words[DATA_W +: DATA_W];

    always_comb begin
        unique case (acc.region)
            RGN_RAM: rd_data = ram_word;
            RGN_FB:  rd_data = fb_words[DATA_W-1:0];
            RGN_KBD: rd_data = kbd_code;
            default: rd_data = '0;
        endcase
    end

    // R4: keyboard address mirrors the keyboard input
    a_r4_kbd_mirror: assert property (@(posedge clk) disable iff (rst)
        (addr == KBD_ADDR) |-> rd_data == kbd_code)
        else $error("a_r4_kbd_mirror");

    // R5: anything past the keyboard word reads zero
    a_r5_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (addr > KBD_ADDR) |-> rd_data == '0)
        else $error("a_r5_unmapped_zero");

    // R6: no store is written at or above the keyboard word
    a_r6_no_store_write: assert property (@(posedge clk) disable iff (rst)
        (addr >= KBD_ADDR) |-> !(acc.ram_we || acc.fb_we))
        else $error("a_r6_no_store_write");

    // R8: reset blocks every write strobe
    a_r8_reset_blocks: assert property (@(posedge clk)
        rst |-> !(acc.ram_we || acc.fb_we))
        else $error("a_r8_reset_blocks");

    // R1: at most one store is strobed per cycle
    a_r1_single_bank: assert property (@(posedge clk) disable iff (rst)
        $countones({acc.ram_we, acc.fb_we}) <= 1)
        else $error("a_r1_single_bank");
endmodule

// File: tb/sim_mmio_datamem.sv
`timescale 1ns/100ps
module sim_mmio_datamem;
    localparam int DW = 16;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] wr_data;
    logic [AW-1:0] addr;
    logic          load;
    logic [DW-1:0] kbd_code;
    logic [DW-1:0] rd_data;
    logic [AW-3:0] pix_addr;
    logic [DW-1:0] pix_data;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    mmio_datamem #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .wr_data(wr_data), .addr(addr), .load(load),
        .kbd_code(kbd_code), .rd_data(rd_data), .pix_addr(pix_addr), .pix_data(pix_data)
    );

    // {load, addr, wr_data, kbd_code, expected read after the edge}
    localparam int NV = 13;
    localparam logic [1+AW+3*DW-1:0] VEC [NV] = '{
        {1'b1, 11'h000, 16'h1234, 16'h0000, 16'h1234},
        {1'b1, 11'h3FF, 16'hBEEF, 16'h0000, 16'hBEEF},
        {1'b1, 11'h400, 16'h00FF, 16'h0000, 16'h00FF},
        {1'b1, 11'h5FF, 16'h8001, 16'h0000, 16'h8001},
        {1'b0, 11'h000, 16'h0000, 16'h0000, 16'h1234},
        {1'b0, 11'h600, 16'h0000, 16'h0041, 16'h0041},
        {1'b0, 11'h600, 16'h0000, 16'h0000, 16'h0000},
        {1'b1, 11'h600, 16'hFFFF, 16'h0020, 16'h0020},
        {1'b1, 11'h7FF, 16'hFFFF, 16'h0000, 16'h0000},
        {1'b0, 11'h601, 16'h0000, 16'h0000, 16'h0000},
        {1'b1, 11'h001, 16'h5555, 16'h0000, 16'h5555},
        {1'b1, 11'h401, 16'hAAAA, 16'h0000, 16'hAAAA},
        {1'b0, 11'h001, 16'h0000, 16'h0000, 16'h5555}
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 1:   return "R1 R2 data write";
            2, 3:   return "R9 frame-buffer write";
            4:      return "R2 data read";
            5, 6:   return "R4 keyboard read";
            7:      return "R6 keyboard write ignored";
            8:      return "R5 unmapped write reads zero";
            9:      return "R5 unmapped read";
            default: return "R3 region separation";
        endcase
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: drive after a falling edge, release load at the next falling edge
    task automatic access(logic ld, logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        load = ld; addr = a; wr_data = d;
        @(negedge clk);
        load = 1'b0;
        #1;
    endtask

    initial begin
        rst = 1'b1; load = 1'b0; addr = '0; wr_data = '0;
        kbd_code = 16'h1111; pix_addr = '0;

        // Reset state: keyboard and unmapped paths are live during reset
        @(negedge clk); addr = 11'h600; #1;
        check("R4 keyboard during reset", rd_data, 16'h1111);
        addr = 11'h700; #1;
        check("R5 unmapped during reset", rd_data, 16'h0000);
        @(negedge clk); rst = 1'b0; kbd_code = '0;

        for (int i = 0; i < NV; i++) begin
            logic [1+AW+3*DW-1:0] v;
            v = VEC[i];
            kbd_code = v[2*DW-1:DW];
            access(v[1+AW+3*DW-1], v[AW+3*DW-1 -: AW], v[3*DW-1 -: DW]);
            check(vec_tag(i), rd_data, v[DW-1:0]);
        end

        // R6: ignored writes left both stores intact at the aliased offsets
        access(1'b0, 11'h3FF, '0);
        check("R6 data top unchanged", rd_data, 16'hBEEF);
        access(1'b0, 11'h000, '0);
        check("R6 data base unchanged", rd_data, 16'h1234);
        pix_addr = 9'h1FF; #1;
        check("R6 frame top unchanged", pix_data, 16'h8001);
        pix_addr = 9'h000; #1;
        check("R6 frame base unchanged", pix_data, 16'h00FF);

        // R3: frame word 1 did not disturb data word 1 and vice versa
        pix_addr = 9'h001; #1;
        check("R3 frame word 1", pix_data, 16'hAAAA);

        // R7: pixel row 3, column 37 is word 32*3+2 = 98, bit 5
        access(1'b1, 11'h400 + 11'd98, 16'h0020);
        pix_addr = 9'd98; #1;
        check("R7 pixel word via display port", pix_data, 16'h0020);
        check("R7 pixel bit black", {15'b0, pix_data[37 % 16]}, 16'h0001);
        access(1'b0, 11'h400 + 11'd98, '0);
        check("R7 same word on processor port", rd_data, pix_data);

        // R8: write under reset is dropped
        access(1'b1, 11'h002, 16'h0F0F);
        @(negedge clk); rst = 1'b1;
        access(1'b1, 11'h002, 16'hDEAD);
        access(1'b1, 11'h400 + 11'd98, 16'hDEAD);
        @(negedge clk); rst = 1'b0;
        access(1'b0, 11'h002, '0);
        check("R8 data write during reset dropped", rd_data, 16'h0F0F);
        pix_addr = 9'd98; #1;
        check("R8 frame write during reset dropped", pix_data, 16'h0020);

        // R2: back-to-back writes to one word, last one wins
        access(1'b1, 11'h010, 16'h0001);
        access(1'b1, 11'h010, 16'h0002);
        check("R2 overwrite", rd_data, 16'h0002);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule